// File: doc/BRIEF.md
# SPI Command Decoder for a Byte-Wide Flash Bridge

This block is an SPI slave that sits between a host controller and a byte-wide parallel NAND flash port. Each frame opens when the host pulls chip-select low. The first byte of the frame is an opcode, and that opcode decides how the bytes after it are treated. Depending on the opcode, the block does one of the following:

- replaces an 8-bit configuration register that drives LED and flash-enable lines;
- switches a separate auxiliary LED on or off;
- forwards host bytes to the flash write strobe;
- streams bytes fetched from the flash read port back on the serial output, with or without a 24-bit address phase first.

The SPI pins are oversampled by the block's own clock through a synchronizer. The serial clock must therefore be several times slower than `clk`. The block drives a half period of at least eight `clk` cycles correctly.

The command state machine has eight states:

- `S_OPCODE`: waiting for the opcode.
- `S_CFG`: expecting the configuration byte.
- `S_WR_FIRST` and `S_WR_STREAM`: write data.
- `S_ADDR`: address bytes.
- `S_GAP`: the idle or dummy byte before read data.
- `S_RD_STREAM`: read data.
- `S_DISCARD`: the rest of the frame is ignored.

Every completed byte moves the machine along these transitions:

- From `S_OPCODE`:
  - 0x09 goes to `S_CFG`.
  - 0x08 goes to `S_WR_FIRST`.
  - 0x0A goes to `S_GAP`.
  - 0x0B goes to `S_ADDR`.
  - Every other value, including 0x0C and 0x0D, goes to `S_DISCARD`.
- `S_CFG` goes to `S_DISCARD`.
- `S_WR_FIRST` goes to `S_WR_STREAM`, and `S_WR_STREAM` stays there.
- `S_ADDR` goes to `S_GAP` after its third byte.
- `S_GAP` goes to `S_RD_STREAM`, and `S_RD_STREAM` stays there.
- Chip-select going high returns any state to `S_OPCODE`.

Top module: `spi_nand_cmd_bridge`

## Requirements
- R1: SPI mode 0 is used: the input is sampled on the rising serial clock edge, the output changes after the falling edge, and bytes are 8 bits, most significant bit first. The first byte of each frame is the opcode, and `spi_sdo` returns 0x00 during it.
- R2: Opcode 0x09 makes the next byte replace `cfg_out` completely. Any further bytes in the same frame leave it unchanged.
- R3: After reset, `cfg_out` is 0x1F, `aux_led_n` is 1, `fetch_addr` is 0, and both flash strobes and `spi_sdo` are low. In `cfg_out`, bits 3..0 are the active-low LED1..LED4 enables, bit 4 is the active-low flash chip enable, and bits 7..5 are general-purpose bits.
- R4: Opcode 0x0C drives `aux_led_n` to 0 and opcode 0x0D drives it to 1, once the opcode byte completes. Neither opcode changes `cfg_out`.
- R5: After opcode 0x08, each received byte is put out on `flash_wr_data` with a one-cycle `flash_wr_stb` when the byte after it completes. The last complete byte before chip-select rises is the host's idle byte and is never forwarded, so a frame of 0x08, N data bytes and one idle byte gives exactly N strobes, in order.
- R6: After opcode 0x0A and one idle byte (which returns 0x00), each further byte returns on `spi_sdo` the next value fetched from the flash read port, in fetch order.
- R7: After opcode 0x0B, three address bytes, most significant first, are loaded together into `fetch_addr` when the third completes. The value holds until the next such load. The dummy byte returns 0x00, the address bytes also return 0x00, and data then follows as in R6.
- R8: The read strobe `flash_rd_stb` is a one-cycle pulse. `flash_rd_data` is sampled in the strobe cycle. The byte for frame position k is fetched when byte k-2 completes, one full byte time before byte k starts shifting. A read frame that returns N data bytes issues N+2 strobes.
- R9: Chip-select going high at any point aborts the command and discards a partial byte. The next frame decodes a fresh opcode, and `spi_sdo` is 0 while chip-select is high.
- R10: An opcode outside 0x08..0x0D makes the block ignore the rest of the frame. There are no strobes, `cfg_out`, `aux_led_n` and `fetch_addr` do not change, and `spi_sdo` returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI serial clock from the host |
| spi_sdi | input | 1 | SPI data from host to block |
| spi_sel_n | input | 1 | SPI chip-select, active low |
| spi_sdo | output | 1 | SPI data from block to host |
| flash_rd_stb | output | 1 | One-cycle read strobe to the flash port |
| flash_rd_data | input | 8 | Flash read byte, valid during the read strobe cycle |
| flash_wr_stb | output | 1 | One-cycle write strobe to the flash port |
| flash_wr_data | output | 8 | Byte written to the flash port, valid with the write strobe |
| cfg_out | output | 8 | Configuration register (LED and chip-enable bits) |
| aux_led_n | output | 1 | Auxiliary LED drive, active low |
| fetch_addr | output | 24 | Address captured by the addressed read command |

## Verification
A wrong state transition shows up on the pins within the byte time that follows it. If the machine stays in the wrong state, `spi_sdo` returns zeros where flash data belongs, or the strobe counts per frame are off by one. A misplaced write hold register either forwards the idle byte or shifts the written data by one position. A read prefetch that is a byte late returns each data byte one position late. The bench counts strobes per frame and compares every returned and forwarded byte against a numbered data pattern, so these errors appear as early as the first data byte of the frame.

// File: rtl/snb_pkg.sv
package snb_pkg;

    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] byte_t;

    localparam byte_t OP_WR_FLASH = 8'h08;
    localparam byte_t OP_SET_CFG  = 8'h09;
    localparam byte_t OP_RD_FLASH = 8'h0A;
    localparam byte_t OP_RD_ADDR  = 8'h0B;
    localparam byte_t OP_AUX_ON   = 8'h0C;
    localparam byte_t OP_AUX_OFF  = 8'h0D;

    typedef enum logic [2:0] {
        S_OPCODE,
        S_CFG,
        S_WR_FIRST,
        S_WR_STREAM,
        S_ADDR,
        S_GAP,
        S_RD_STREAM,
        S_DISCARD
    } cmd_state_e;

endpackage

// File: rtl/snb_sync.sv
module snb_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= {STAGES{RST_VAL}};
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/snb_spi_shift.sv
module snb_spi_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sck,
    input  logic         sdi,
    input  logic         sel_n,
    input  logic [W-1:0] tx_byte,
    output logic [W-1:0] rx_byte,
    output logic         word_done,
    output logic         sdo
);

    localparam int CNT_W = $clog2(W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(W - 1);

    logic             sck_q;
    logic [CNT_W-1:0] bit_q;
    logic [W-1:0]     rx_sh;
    logic [W-1:0]     tx_sh;
    logic             rise;
    logic             fall;

    assign rise      = sck & ~sck_q;
    assign fall      = ~sck & sck_q;
    assign word_done = rise & ~sel_n & (bit_q == LAST_BIT);
    assign rx_byte   = {rx_sh[W-2:0], sdi};
    assign sdo       = tx_sh[W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            bit_q <= '0;
            rx_sh <= '0;
            tx_sh <= '0;
        end else begin
            sck_q <= sck;
            if (sel_n) begin
                bit_q <= '0;
                rx_sh <= '0;
                tx_sh <= '0;
            end else begin
                if (rise) begin
                    rx_sh <= rx_byte;
                    bit_q <= (bit_q == LAST_BIT) ? '0 : bit_q + 1'b1;
                end
                if (word_done) begin
                    tx_sh <= tx_byte;
                end else if (fall && (bit_q != '0)) begin
                    tx_sh <= {tx_sh[W-2:0], 1'b0};
                end
            end
        end
    end

    // R9: serial output is quiet while the frame is closed
    p_sdo_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (sdo == 1'b0));

    // R1: a byte completes on one cycle only
    p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> !word_done);

endmodule

// File: rtl/snb_cmd_fsm.sv
module snb_cmd_fsm
    import snb_pkg::*;
#(
    parameter int    ADDR_BYTES = 3,
    parameter byte_t CFG_RST    = 8'h1F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sel_n,
    input  logic                    word_done,
    input  byte_t                   rx_byte,
    output byte_t                   tx_byte,
    output logic                    rd_stb,
    input  byte_t                   rd_data,
    output logic                    wr_stb,
    output byte_t                   wr_data,
    output byte_t                   cfg,
    output logic                    led_n,
    output logic [ADDR_BYTES*8-1:0] addr
);

    localparam int ADDR_W = ADDR_BYTES * BYTE_W;
    localparam int ACNT_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_BYTES - 1);

    cmd_state_e        state_q, state_d;
    byte_t             cfg_q, hold_q, prefetch_q, wr_data_q;
    logic              led_q, rd_stb_q, wr_stb_q;
    logic [ADDR_W-1:0] addr_q, addr_sh_q;
    logic [ACNT_W-1:0] acnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OPCODE;
        end else if (sel_n) begin
            state_q <= S_OPCODE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decode, advanced once per completed byte
    always_comb begin
        state_d = state_q;
        if (word_done) begin
            unique case (state_q)
                S_OPCODE: begin
                    case (rx_byte)
                        OP_SET_CFG:  state_d = S_CFG;
                        OP_WR_FLASH: state_d = S_WR_FIRST;
                        OP_RD_FLASH: state_d = S_GAP;
                        OP_RD_ADDR:  state_d = S_ADDR;
                        default:     state_d = S_DISCARD;
                    endcase
                end
                S_CFG:       state_d = S_DISCARD;
                S_WR_FIRST:  state_d = S_WR_STREAM;
                S_WR_STREAM: state_d = S_WR_STREAM;
                S_ADDR:      state_d = (acnt_q == ACNT_LAST) ? S_GAP : S_ADDR;
                S_GAP:       state_d = S_RD_STREAM;
                S_RD_STREAM: state_d = S_RD_STREAM;
                S_DISCARD:   state_d = S_DISCARD;
            endcase
        end
    end

    // byte to shift out next: prefetched flash data in read phases
    always_comb begin
        tx_byte = '0;
        if (state_q == S_GAP || state_q == S_RD_STREAM) begin
            tx_byte = prefetch_q;
        end
    end

    // outputs and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= CFG_RST;
            led_q      <= 1'b1;
            addr_q     <= '0;
            addr_sh_q  <= '0;
            acnt_q     <= '0;
            hold_q     <= '0;
            prefetch_q <= '0;
            wr_data_q  <= '0;
            rd_stb_q   <= 1'b0;
            wr_stb_q   <= 1'b0;
        end else begin
            rd_stb_q <= 1'b0;
            wr_stb_q <= 1'b0;
            if (rd_stb_q) begin
                prefetch_q <= rd_data;
            end
            if (sel_n) begin
                acnt_q <= '0;
            end else if (word_done) begin
                unique case (state_q)
                    S_OPCODE: begin
                        if (rx_byte == OP_RD_FLASH) rd_stb_q <= 1'b1;
                        if (rx_byte == OP_AUX_ON)   led_q    <= 1'b0;
                        if (rx_byte == OP_AUX_OFF)  led_q    <= 1'b1;
                    end
                    S_CFG: cfg_q <= rx_byte;
                    S_WR_FIRST: hold_q <= rx_byte;
                    S_WR_STREAM: begin
                        wr_stb_q  <= 1'b1;
                        wr_data_q <= hold_q;
                        hold_q    <= rx_byte;
                    end
                    S_ADDR: begin
                        addr_sh_q <= {addr_sh_q[ADDR_W-BYTE_W-1:0], rx_byte};
                        if (acnt_q == ACNT_LAST) begin
                            addr_q   <= {addr_sh_q[ADDR_W-BYTE_W-1:0], rx_byte};
                            acnt_q   <= '0;
                            rd_stb_q <= 1'b1;
                        end else begin
                            acnt_q <= acnt_q + 1'b1;
                        end
                    end
                    S_GAP, S_RD_STREAM: rd_stb_q <= 1'b1;
                    S_DISCARD: ;
                endcase
            end
        end
    end

    assign cfg     = cfg_q;
    assign led_n   = led_q;
    assign addr    = addr_q;
    assign rd_stb  = rd_stb_q;
    assign wr_stb  = wr_stb_q;
    assign wr_data = wr_data_q;

    // R9: a closed frame always leaves the decoder waiting for an opcode
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n |=> (state_q == S_OPCODE));

    // R5: never read and write in the same cycle
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_stb_q && wr_stb_q));

    // R5: write strobe lasts one cycle
    p_wr_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb_q |=> !wr_stb_q);

    // R8: read strobe lasts one cycle
    p_rd_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb_q |=> !rd_stb_q);

    // R2: configuration only changes after the byte following its opcode
    p_cfg_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q != $past(cfg_q)) |-> ($past(state_q) == S_CFG));

    // R4: the auxiliary LED only changes on an opcode byte
    p_led_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (led_q != $past(led_q)) |-> ($past(state_q) == S_OPCODE));

    // R7: the visible address only changes at the end of the address phase
    p_addr_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_q != $past(addr_q)) |-> ($past(state_q) == S_ADDR));

    // R10: an ignored frame produces no strobes and zero output data
    p_discard_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DISCARD) |-> (!rd_stb_q && !wr_stb_q && tx_byte == '0));

endmodule

// File: rtl/spi_nand_cmd_bridge.sv
module spi_nand_cmd_bridge #(
    parameter int          SYNC_STAGES = 2,
    parameter int          ADDR_BYTES  = 3,
    parameter logic [7:0]  CFG_RST     = 8'h1F
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    spi_sck,
    input  logic                    spi_sdi,
    input  logic                    spi_sel_n,
    output logic                    spi_sdo,
    output logic                    flash_rd_stb,
    input  logic [7:0]              flash_rd_data,
    output logic                    flash_wr_stb,
    output logic [7:0]              flash_wr_data,
    output logic [7:0]              cfg_out,
    output logic                    aux_led_n,
    output logic [ADDR_BYTES*8-1:0] fetch_addr
);

    import snb_pkg::*;

    logic [2:0] pins_s;
    logic       sck_s, sdi_s, sel_n_s;
    byte_t      rx_byte, tx_byte;
    logic       word_done;

    snb_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({spi_sck, spi_sdi, spi_sel_n}),
        .q     (pins_s)
    );

    assign sck_s   = pins_s[2];
    assign sdi_s   = pins_s[1];
    assign sel_n_s = pins_s[0];

    snb_spi_shift #(
        .W (BYTE_W)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck_s),
        .sdi       (sdi_s),
        .sel_n     (sel_n_s),
        .tx_byte   (tx_byte),
        .rx_byte   (rx_byte),
        .word_done (word_done),
        .sdo       (spi_sdo)
    );

    snb_cmd_fsm #(
        .ADDR_BYTES (ADDR_BYTES),
        .CFG_RST    (CFG_RST)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_n_s),
        .word_done (word_done),
        .rx_byte   (rx_byte),
        .tx_byte   (tx_byte),
        .rd_stb    (flash_rd_stb),
        .rd_data   (flash_rd_data),
        .wr_stb    (flash_wr_stb),
        .wr_data   (flash_wr_data),
        .cfg       (cfg_out),
        .led_n     (aux_led_n),
        .addr      (fetch_addr)
    );

endmodule

// File: tb/sim_spi_nand_cmd_bridge.sv
`timescale 1ns/1ps
module sim_spi_nand_cmd_bridge;

    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0, spi_sdi = 1'b0, spi_sel_n = 1'b1;
    logic        spi_sdo, flash_rd_stb, flash_wr_stb, aux_led_n;
    logic [7:0]  flash_rd_data, flash_wr_data, cfg_out;
    logic [23:0] fetch_addr;

    int n_cmp = 0;
    int n_bad = 0;
    int rd_idx = 0;
    int wr_cnt = 0;
    bit finished = 1'b0;
    logic [7:0] wr_log [0:255];
    logic [7:0] mo [0:31];
    logic [7:0] mi [0:31];

    always #4 clk = ~clk;

    spi_nand_cmd_bridge u0 (
        .clk(clk), .rst_n(rst_n),
        .spi_sck(spi_sck), .spi_sdi(spi_sdi), .spi_sel_n(spi_sel_n), .spi_sdo(spi_sdo),
        .flash_rd_stb(flash_rd_stb), .flash_rd_data(flash_rd_data),
        .flash_wr_stb(flash_wr_stb), .flash_wr_data(flash_wr_data),
        .cfg_out(cfg_out), .aux_led_n(aux_led_n), .fetch_addr(fetch_addr)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 29 + 90);
    endfunction

    assign flash_rd_data = pat(rd_idx);

    always @(posedge clk) begin
        if (flash_rd_stb) rd_idx <= rd_idx + 1;
        if (flash_wr_stb) begin
            wr_log[wr_cnt[7:0]] <= flash_wr_data;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic xfer(input int nb, input int tail_bits);
        spi_sel_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nb + (tail_bits > 0 ? 1 : 0); b++) begin
            int nbits;
            logic [7:0] got;
            nbits = (b < nb) ? 8 : tail_bits;
            got = 8'h00;
            for (int k = 0; k < nbits; k++) begin
                spi_sdi = mo[b][7-k];
                repeat (HALF) @(negedge clk);
                got = {got[6:0], spi_sdo};
                spi_sck = 1'b1;
                repeat (HALF) @(negedge clk);
                spi_sck = 1'b0;
            end
            mi[b] = got;
        end
        repeat (HALF) @(negedge clk);
        spi_sel_n = 1'b1;
        repeat (4 * HALF) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] cfg_keep;
        logic       led_keep;
        logic [23:0] addr_keep;
        int base, w0, n;
        void'($urandom(32'd7719));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R3: reset state
        chk("R3 cfg", cfg_out, 8'h1F);
        chk("R3 led", aux_led_n, 1);
        chk("R3 addr", fetch_addr, 0);
        chk("R3 strobes", {flash_rd_stb, flash_wr_stb}, 0);
        chk("R3 sdo", spi_sdo, 0);

        // R1 / R2: MSB-first config write, opcode byte returns zero
        mo[0] = 8'h09; mo[1] = 8'hC1;
        xfer(2, 0);
        chk("R1 msb first", cfg_out, 8'hC1);
        chk("R1 opcode sdo", mi[0], 0);
        mo[0] = 8'h09; mo[1] = 8'h3C; mo[2] = 8'hFF; mo[3] = 8'h00;
        xfer(4, 0);
        chk("R2 extra bytes", cfg_out, 8'h3C);

        // R4: auxiliary LED
        mo[0] = 8'h0C;
        xfer(1, 0);
        chk("R4 on", aux_led_n, 0);
        chk("R4 cfg kept", cfg_out, 8'h3C);
        mo[0] = 8'h0D;
        xfer(1, 0);
        chk("R4 off", aux_led_n, 1);

        // R5: flash writes, idle byte dropped
        for (int it = 0; it < 8; it++) begin
            n = (it == 0) ? 0 : $urandom_range(1, 7);
            w0 = wr_cnt;
            base = rd_idx;
            mo[0] = 8'h08;
            for (int i = 0; i < n; i++) mo[i+1] = 8'($urandom);
            mo[n+1] = 8'($urandom);
            xfer(n + 2, 0);
            chk("R5 write count", wr_cnt - w0, n);
            for (int i = 0; i < n; i++) chk("R5 write data", wr_log[(w0 + i) % 256], mo[i+1]);
            chk("R5 no reads", rd_idx - base, 0);
        end

        // R6 / R8: plain flash read
        for (int it = 0; it < 6; it++) begin
            n = $urandom_range(1, 6);
            base = rd_idx;
            mo[0] = 8'h0A;
            for (int i = 1; i < n + 2; i++) mo[i] = 8'($urandom);
            xfer(n + 2, 0);
            chk("R6 idle sdo", {mi[0], mi[1]}, 0);
            for (int j = 0; j < n; j++) chk("R6 read data", mi[2+j], pat(base + j));
            chk("R8 strobe count", rd_idx - base, n + 2);
        end

        // R7 / R8: addressed read
        for (int it = 0; it < 6; it++) begin
            logic [23:0] a;
            a = 24'($urandom);
            n = $urandom_range(1, 5);
            base = rd_idx;
            mo[0] = 8'h0B; mo[1] = a[23:16]; mo[2] = a[15:8]; mo[3] = a[7:0];
            for (int i = 4; i < n + 5; i++) mo[i] = 8'($urandom);
            xfer(n + 5, 0);
            chk("R7 address", fetch_addr, a);
            chk("R7 header sdo", {mi[0], mi[1], mi[2], mi[3], mi[4]}, 0);
            for (int j = 0; j < n; j++) chk("R7 read data", mi[5+j], pat(base + j));
            chk("R8 strobe count", rd_idx - base, n + 2);
        end

        // R9: aborts
        cfg_keep = cfg_out;
        mo[0] = 8'h09; mo[1] = 8'h00;
        xfer(1, 5);
        chk("R9 partial cfg", cfg_out, cfg_keep);
        mo[0] = 8'h0C;
        xfer(1, 0);
        chk("R9 fresh opcode", aux_led_n, 0);
        mo[0] = 8'h0D;
        xfer(0, 6);
        chk("R9 partial opcode", aux_led_n, 0);
        xfer(1, 0);
        chk("R9 after partial", aux_led_n, 1);
        addr_keep = fetch_addr;
        mo[0] = 8'h0B; mo[1] = 8'h11; mo[2] = 8'h22;
        xfer(3, 0);
        chk("R9 partial address", fetch_addr, addr_keep);
        w0 = wr_cnt;
        mo[0] = 8'h08; mo[1] = 8'hAA; mo[2] = 8'hBB;
        xfer(2, 4);
        chk("R9 partial write", wr_cnt - w0, 0);
        chk("R9 sdo idle", spi_sdo, 0);

        // R10: unknown opcodes
        for (int it = 0; it < 4; it++) begin
            logic [7:0] op;
            op = 8'($urandom);
            while (op >= 8'h08 && op <= 8'h0D) op = 8'($urandom);
            mo[0] = op;
            for (int i = 1; i < 5; i++) mo[i] = 8'($urandom);
            cfg_keep = cfg_out; led_keep = aux_led_n; addr_keep = fetch_addr;
            base = rd_idx; w0 = wr_cnt;
            xfer(5, 0);
            chk("R10 sdo zero", {mi[1], mi[2], mi[3], mi[4]}, 0);
            chk("R10 no strobes", (rd_idx - base) + (wr_cnt - w0), 0);
            chk("R10 state kept", {cfg_out, aux_led_n, fetch_addr}, {cfg_keep, led_keep, addr_keep});
        end

        finish_run();
    end

endmodule